// File: doc/BRIEF.md
# Register Pair Wide Increment, Decrement and Double-Add Unit

This block keeps three 16-bit register pairs, named BC, DE and HL, plus one carry bit. On a strobed command it does one of three things. It can step a chosen pair up by one across its full width. It can step a chosen pair down by one. It can add a chosen pair into HL, so that HL works as a 16-bit accumulator. The increment and decrement never touch the carry. The double add is the only operation that writes the carry.

A separate load port for each pair presets that pair directly. A load on a pair wins over any command that would write the same pair in that cycle. All results are registered, so a command or load presented before a rising edge shows on the outputs just after that edge.

Top module: `rp_wide_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all three pairs and `carry_q` become 0.
- R2: A valid command with `cmd_op`=00 (increment) and `cmd_sel` 00=BC, 01=DE or 10=HL adds 1 to the whole selected pair. The carry crosses the byte boundary (F8FFh becomes F900h). The other pairs are unchanged.
- R3: A valid command with `cmd_op`=01 (decrement) subtracts 1 from the whole selected pair. The borrow crosses the byte boundary (F900h becomes F8FFh). The other pairs are unchanged.
- R4: Increment and decrement leave `carry_q` unchanged, whether it is 0 or 1.
- R5: Increment of FFFFh gives 0000h and decrement of 0000h gives FFFFh. Nothing is signalled, and `carry_q` is unchanged.
- R6: A valid command with `cmd_op`=10 (double add) and `cmd_sel` BC or DE writes the low 16 bits of HL plus the selected pair into HL. It sets `carry_q` to the carry out of bit 15. The source pair is unchanged.
- R7: A double add with `cmd_sel`=10 (HL) doubles HL, and `carry_q` takes the old bit 15 of HL.
- R8: A valid command with `cmd_sel`=11, or with `cmd_op`=11, changes no pair and no carry.
- R9: When `cmd_valid` is low, no pair and no carry change.
- R10: A load enable writes its data word into its pair at the next edge. It leaves `carry_q` unchanged.
- R11: When a load and a command target the same pair in the same cycle, the load value is stored and the command is dropped entirely, so a double add dropped this way leaves `carry_q` unchanged. A load on a different pair does not stop the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 increment, 01 decrement, 10 double add, 11 reserved |
| cmd_sel | input | 2 | 00 BC, 01 DE, 10 HL, 11 unused |
| ld_bc_en | input | 1 | Load enable for BC |
| ld_bc_data | input | 16 | Load value for BC |
| ld_de_en | input | 1 | Load enable for DE |
| ld_de_data | input | 16 | Load value for DE |
| ld_hl_en | input | 1 | Load enable for HL |
| ld_hl_data | input | 16 | Load value for HL |
| bc_q | output | 16 | Current BC |
| de_q | output | 16 | Current DE |
| hl_q | output | 16 | Current HL |
| carry_q | output | 1 | Carry bit |

## Verification
The bench sweeps every pair through both step directions, using boundary words 00FFh, F8FFh, F900h, 7FFFh, 8000h and FFFFh, each with the carry preset to 0 and to 1.

Each corner case targets a specific fault:
- A unit that stepped only the low byte would show F800h instead of F900h.
- A unit whose increment drove the carry would flip it on the FFFFh wrap.
- The double-add sweep crosses the carry boundary. The HL-to-HL case catches a unit that read the operand after writing it.
- Reserved codes, the idle strobe and load collisions catch a unit that writes a pair or the carry when it must hold them.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int NUM_PAIRS = 3;
    localparam int IDX_W     = 2;

    typedef enum logic [1:0] {
        OP_INC = 2'b00,
        OP_DEC = 2'b01,
        OP_DAD = 2'b10,
        OP_RSV = 2'b11
    } rp_op_e;

    typedef enum logic [1:0] {
        SEL_BC   = 2'b00,
        SEL_DE   = 2'b01,
        SEL_HL   = 2'b10,
        SEL_NONE = 2'b11
    } rp_sel_e;

    typedef struct packed {
        logic    valid;
        rp_op_e  op;
        rp_sel_e sel;
    } rp_cmd_t;

    function automatic logic sel_names_pair(input rp_sel_e s);
        return (s != SEL_NONE);
    endfunction

endpackage

// File: rtl/rp_operand_mux.sv
module rp_operand_mux
    import rp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [NUM_PAIRS-1:0][W-1:0] pairs,
    input  rp_sel_e                     sel,
    output logic [W-1:0]                operand,
    output logic                        sel_ok
);
    always_comb begin
        operand = '0;
        sel_ok  = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (sel == rp_sel_e'(i)) begin
                operand = pairs[i];
                sel_ok  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rp_arith_core.sv
module rp_arith_core
    import rp_pkg::*;
#(
    parameter int W = 16
) (
    input  rp_cmd_t          cmd,
    input  logic             sel_ok,
    input  logic [W-1:0]     operand,
    input  logic [W-1:0]     acc,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [W-1:0]     wr_data,
    output logic             cy_en,
    output logic             cy_d
);
    logic [W-1:0] stepped_up;
    logic [W-1:0] stepped_dn;
    logic [W:0]   wide_sum;

    assign stepped_up = operand + W'(1);
    assign stepped_dn = operand - W'(1);
    assign wide_sum   = {1'b0, acc} + {1'b0, operand};

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = IDX_W'(cmd.sel);
        wr_data = '0;
        cy_en   = 1'b0;
        cy_d    = 1'b0;
        if (cmd.valid && sel_ok && sel_names_pair(cmd.sel)) begin
            unique case (cmd.op)
                OP_INC: begin
                    wr_en   = 1'b1;
                    wr_data = stepped_up;
                end
                OP_DEC: begin
                    wr_en   = 1'b1;
                    wr_data = stepped_dn;
                end
                OP_DAD: begin
                    wr_en   = 1'b1;
                    wr_idx  = IDX_W'(SEL_HL);
                    wr_data = wide_sum[W-1:0];
                    cy_en   = 1'b1;
                    cy_d    = wide_sum[W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rp_pair_bank.sv
module rp_pair_bank
    import rp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PAIRS-1:0]        ld_en,
    input  logic [NUM_PAIRS-1:0][W-1:0] ld_data,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [W-1:0]                wr_data,
    input  logic                        cy_en,
    input  logic                        cy_d,
    output logic [NUM_PAIRS-1:0][W-1:0] pairs_q,
    output logic                        cy_q
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                pairs_q[g] <= '0;
            end else if (ld_en[g]) begin
                pairs_q[g] <= ld_data[g];
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                pairs_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cy_q <= 1'b0;
        end else if (cy_en) begin
            cy_q <= cy_d;
        end
    end
endmodule

// File: rtl/rp_wide_unit.sv
module rp_wide_unit
    import rp_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_sel,
    input  logic              ld_bc_en,
    input  logic [PAIR_W-1:0] ld_bc_data,
    input  logic              ld_de_en,
    input  logic [PAIR_W-1:0] ld_de_data,
    input  logic              ld_hl_en,
    input  logic [PAIR_W-1:0] ld_hl_data,
    output logic [PAIR_W-1:0] bc_q,
    output logic [PAIR_W-1:0] de_q,
    output logic [PAIR_W-1:0] hl_q,
    output logic              carry_q
);
    rp_cmd_t                          cmd;
    logic [NUM_PAIRS-1:0][PAIR_W-1:0] pairs;
    logic [NUM_PAIRS-1:0][PAIR_W-1:0] ld_data;
    logic [NUM_PAIRS-1:0]             ld_en;
    logic [PAIR_W-1:0]                operand;
    logic                             sel_ok;
    logic                             raw_wr_en;
    logic [IDX_W-1:0]                 wr_idx;
    logic [PAIR_W-1:0]                wr_data;
    logic                             raw_cy_en;
    logic                             cy_d;
    logic                             collide;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = rp_op_e'(cmd_op);
    assign cmd.sel   = rp_sel_e'(cmd_sel);

    assign ld_en   = {ld_hl_en, ld_de_en, ld_bc_en};
    assign ld_data = {ld_hl_data, ld_de_data, ld_bc_data};

    rp_operand_mux #(.W(PAIR_W)) u_mux (
        .pairs   (pairs),
        .sel     (cmd.sel),
        .operand (operand),
        .sel_ok  (sel_ok)
    );

    rp_arith_core #(.W(PAIR_W)) u_core (
        .cmd     (cmd),
        .sel_ok  (sel_ok),
        .operand (operand),
        .acc     (pairs[SEL_HL]),
        .wr_en   (raw_wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cy_en   (raw_cy_en),
        .cy_d    (cy_d)
    );

    // a load on the destination pair cancels the whole command
    always_comb begin
        collide = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (ld_en[i] && (wr_idx == IDX_W'(i))) collide = 1'b1;
        end
    end

    rp_pair_bank #(.W(PAIR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_data (ld_data),
        .wr_en   (raw_wr_en && !collide),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cy_en   (raw_cy_en && !collide),
        .cy_d    (cy_d),
        .pairs_q (pairs),
        .cy_q    (carry_q)
    );

    assign bc_q = pairs[SEL_BC];
    assign de_q = pairs[SEL_DE];
    assign hl_q = pairs[SEL_HL];
endmodule

// File: rtl/rp_wide_unit_chk.sv
module rp_wide_unit_chk #(
    parameter int PAIR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [1:0]        cmd_sel,
    input logic              ld_bc_en,
    input logic [PAIR_W-1:0] ld_bc_data,
    input logic              ld_de_en,
    input logic              ld_hl_en,
    input logic [PAIR_W-1:0] ld_hl_data,
    input logic [PAIR_W-1:0] bc_q,
    input logic [PAIR_W-1:0] de_q,
    input logic [PAIR_W-1:0] hl_q,
    input logic              carry_q
);
    logic no_loads;
    assign no_loads = !ld_bc_en && !ld_de_en && !ld_hl_en;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (bc_q == '0 && de_q == '0 && hl_q == '0 && !carry_q));

    p_inc_bc_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b00 && cmd_sel == 2'b00 && !ld_bc_en)
        |=> bc_q == $past(bc_q) + PAIR_W'(1));

    p_dec_de_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b01 && cmd_sel == 2'b01 && !ld_de_en)
        |=> de_q == $past(de_q) - PAIR_W'(1));

    p_step_keeps_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_op[1]) |=> $stable(carry_q));

    p_dad_bc_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10 && cmd_sel == 2'b00 && !ld_hl_en)
        |=> {carry_q, hl_q} == {1'b0, $past(hl_q)} + {1'b0, $past(bc_q)});

    p_dad_self_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10 && cmd_sel == 2'b10 && !ld_hl_en)
        |=> (carry_q == $past(hl_q[PAIR_W-1]) && hl_q == {$past(hl_q[PAIR_W-2:0]), 1'b0}));

    p_unused_sel_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_sel == 2'b11 && no_loads)
        |=> ($stable(bc_q) && $stable(de_q) && $stable(hl_q) && $stable(carry_q)));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && no_loads)
        |=> ($stable(bc_q) && $stable(de_q) && $stable(hl_q) && $stable(carry_q)));

    p_load_bc_r10: assert property (@(posedge clk) disable iff (rst)
        ld_bc_en |=> bc_q == $past(ld_bc_data));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (ld_hl_en && cmd_valid && cmd_op == 2'b10)
        |=> (hl_q == $past(ld_hl_data) && $stable(carry_q)));
endmodule

bind rp_wide_unit rp_wide_unit_chk #(.PAIR_W(PAIR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_sel    (cmd_sel),
    .ld_bc_en   (ld_bc_en),
    .ld_bc_data (ld_bc_data),
    .ld_de_en   (ld_de_en),
    .ld_hl_en   (ld_hl_en),
    .ld_hl_data (ld_hl_data),
    .bc_q       (bc_q),
    .de_q       (de_q),
    .hl_q       (hl_q),
    .carry_q    (carry_q)
);

// File: tb/tb_rp_wide_unit.sv
`timescale 1ns/1ps
module tb_rp_wide_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_sel;
    logic        ld_bc_en, ld_de_en, ld_hl_en;
    logic [15:0] ld_bc_data, ld_de_data, ld_hl_data;
    logic [15:0] bc_q, de_q, hl_q;
    logic        carry_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] exp_p [3];
    logic        exp_cy;

    logic [15:0] pats [8] = '{16'h0000, 16'h0001, 16'h00FF, 16'hF8FF,
                               16'hF900, 16'h7FFF, 16'h8000, 16'hFFFF};

    always #2.5 clk = ~clk;

    rp_wide_unit dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
        .ld_bc_en(ld_bc_en), .ld_bc_data(ld_bc_data),
        .ld_de_en(ld_de_en), .ld_de_data(ld_de_data),
        .ld_hl_en(ld_hl_en), .ld_hl_data(ld_hl_data),
        .bc_q(bc_q), .de_q(de_q), .hl_q(hl_q), .carry_q(carry_q)
    );

    task automatic compare(input string req);
        checks++;
        if (bc_q !== exp_p[0] || de_q !== exp_p[1] || hl_q !== exp_p[2] || carry_q !== exp_cy) begin
            errors++;
            $display("FAIL %s: got bc=%h de=%h hl=%h cy=%b expected bc=%h de=%h hl=%h cy=%b",
                     req, bc_q, de_q, hl_q, carry_q, exp_p[0], exp_p[1], exp_p[2], exp_cy);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(input logic v, input logic [1:0] op, input logic [1:0] sel,
                        input logic [2:0] ld, input logic [15:0] lb, input logic [15:0] ldd,
                        input logic [15:0] lh, input string req);
        logic [15:0] np [3];
        logic        ncy;
        logic [16:0] s;
        int          dst;
        for (int i = 0; i < 3; i++) np[i] = exp_p[i];
        ncy = exp_cy;
        if (v && sel != 2'b11 && op != 2'b11) begin
            dst = (op == 2'b10) ? 2 : int'(sel);
            if (!ld[dst]) begin
                if (op == 2'b00) np[dst] = exp_p[dst] + 16'd1;
                else if (op == 2'b01) np[dst] = exp_p[dst] - 16'd1;
                else begin
                    s = {1'b0, exp_p[2]} + {1'b0, exp_p[int'(sel)]};
                    np[2] = s[15:0];
                    ncy = s[16];
                end
            end
        end
        if (ld[0]) np[0] = lb;
        if (ld[1]) np[1] = ldd;
        if (ld[2]) np[2] = lh;
        cmd_valid = v; cmd_op = op; cmd_sel = sel;
        ld_bc_en = ld[0]; ld_de_en = ld[1]; ld_hl_en = ld[2];
        ld_bc_data = lb; ld_de_data = ldd; ld_hl_data = lh;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; ld_bc_en = 1'b0; ld_de_en = 1'b0; ld_hl_en = 1'b0;
        for (int i = 0; i < 3; i++) exp_p[i] = np[i];
        exp_cy = ncy;
        compare(req);
    endtask

    task automatic set_carry(input logic c);
        step(1'b0, 2'b00, 2'b00, 3'b101, c ? 16'h0001 : 16'h0000, 16'h0, c ? 16'hFFFF : 16'h0000, "R10 preset");
        step(1'b1, 2'b10, 2'b00, 3'b000, 16'h0, 16'h0, 16'h0, "R6 carry preset");
    endtask

    task automatic load_all(input logic [15:0] b, input logic [15:0] d, input logic [15:0] h);
        step(1'b0, 2'b00, 2'b00, 3'b111, b, d, h, "R10 load");
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_sel = 2'b00;
        ld_bc_en = 1'b0; ld_de_en = 1'b0; ld_hl_en = 1'b0;
        ld_bc_data = '0; ld_de_data = '0; ld_hl_data = '0;
        for (int i = 0; i < 3; i++) exp_p[i] = '0;
        exp_cy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state");
        rst = 1'b0;

        // R2 R3 R4 R5: every pair, both directions, boundary words, carry 0 and 1
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int op = 0; op < 2; op++) begin
                        set_carry(c[0]);
                        load_all(16'h1234, 16'h5678, 16'h9ABC);
                        step(1'b0, 2'b00, 2'b00, 3'b001 << p, pats[k], pats[k], pats[k], "R10 load one");
                        step(1'b1, op[1:0], p[1:0], 3'b000, 16'h0, 16'h0, 16'h0,
                             (op == 0) ? "R2 R4 R5 increment" : "R3 R4 R5 decrement");
                    end
                end
            end
        end

        // R6: double add BC or DE into HL over the boundary words
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    load_all(pats[a], pats[a], pats[b]);
                    step(1'b1, 2'b10, s[1:0], 3'b000, 16'h0, 16'h0, 16'h0, "R6 double add");
                end
            end
        end

        // R7: HL doubled
        for (int a = 0; a < 8; a++) begin
            set_carry(a[0]);
            load_all(16'hAAAA, 16'h5555, pats[a]);
            step(1'b1, 2'b10, 2'b10, 3'b000, 16'h0, 16'h0, 16'h0, "R7 double HL");
        end

        // R8: unused selector and reserved op
        set_carry(1'b1);
        load_all(16'hFFFF, 16'h0000, 16'h8000);
        for (int op = 0; op < 4; op++)
            step(1'b1, op[1:0], 2'b11, 3'b000, 16'h0, 16'h0, 16'h0, "R8 unused selector");
        for (int s = 0; s < 4; s++)
            step(1'b1, 2'b11, s[1:0], 3'b000, 16'h0, 16'h0, 16'h0, "R8 reserved op");

        // R9: no strobe
        for (int op = 0; op < 4; op++)
            step(1'b0, op[1:0], 2'b00, 3'b000, 16'h0, 16'h0, 16'h0, "R9 strobe low");

        // R11: load wins on the same pair; other pair still operates
        for (int p = 0; p < 3; p++) begin
            load_all(16'h00FF, 16'hF900, 16'hFFFF);
            step(1'b1, 2'b00, p[1:0], 3'b001 << p, 16'hCAFE, 16'hBEEF, 16'h0F0F, "R11 load beats increment");
            step(1'b1, 2'b01, p[1:0], 3'b001 << ((p + 1) % 3), 16'h1111, 16'h2222, 16'h3333, "R11 other pair load");
        end
        set_carry(1'b0);
        load_all(16'hFFFF, 16'h0001, 16'hFFFF);
        step(1'b1, 2'b10, 2'b00, 3'b100, 16'h0, 16'h0, 16'h4321, "R11 load beats double add");
        step(1'b1, 2'b10, 2'b01, 3'b001, 16'h7777, 16'h0, 16'h0, "R11 source load with double add");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule